// File: doc/BRIEF.md
# Edge-Triggered Pin Interrupt Unit

This block watches a bank of asynchronous input pins and turns selected transitions on them into a single interrupt request. Each pin is brought into the clock domain through a two-flop synchronizer. A third register holds the previous synchronized value, so a transition can be recognised by comparing the two. Per pin, software chooses a trigger: rising only, falling only, or either edge.

A recognised transition sets a sticky status bit. The bit stays set until software clears it by writing a 1 to its position. A registered interrupt request is raised whenever a status bit and its matching enable bit are both set. Configuration and status sit behind a small word-wide register port with byte-lane selects. Register index 8 holds the enables, 9 the status, 10 the both-edge bits and 11 the edge-select bits.

Top module: `gpio_edge_irq`

## Requirements
- R1: After a synchronous active-high reset, the enable, status, both-edge and edge-select registers read 0 and `irq` is 0.
- R2: A pin change that is set up before clock edge k sets its status bit at edge k+2 and is visible on `irq` after edge k+3. This covers two synchronizer stages plus the previous-value stage, with the enable bit set.
- R3: With the pin's both-edge bit 0 and its select bit 1, only a 0-to-1 transition of the synchronized pin sets its status bit.
- R4: With the pin's both-edge bit 0 and its select bit 0, only a 1-to-0 transition sets its status bit.
- R5: With the pin's both-edge bit 1, both transitions set the status bit, whatever the select bit holds.
- R6: A status bit latches whether or not its enable bit is set. It stays set until it is cleared by a write.
- R7: A write to index 9 clears exactly the status bits whose data bit is 1 within byte lanes whose select bit is 1. Zero data bits and unselected lanes leave status unchanged. Lane l covers bits 8l to 8l+7.
- R8: If a trigger for a pin arrives on the same edge as a write that clears that pin's status bit, the bit ends up set.
- R9: `irq` equals, one cycle late, the OR over all pins of status AND enable.
- R10: Indices 8, 10 and 11 are read/write per byte lane. A write to any other index changes no register. A read with `reg_stb`=1 and `reg_we`=0 loads `reg_rdata` on that edge, and unknown indices read 0.
- R11: Writing 1s to index 9 never sets a status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_stb | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_idx | input | 4 | Register index (8 enable, 9 status, 10 both-edge, 11 edge-select) |
| reg_be | input | NPINS/8 | Byte-lane selects for writes |
| reg_wdata | input | NPINS | Write data |
| reg_rdata | output | NPINS | Registered read data |
| pin_in | input | NPINS | Asynchronous input pins |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench sweeps every pin through each of the four both-edge/select combinations in both transition directions. A wrong edge polarity or a select that overrides the both-edge bit would show up as a missing or unexpected status bit or `irq`.

A dedicated case lines up a clear write with a trigger on the same edge. A design where the clear wins would lose that event.

Byte-lane clearing is checked with one event in every lane. A design that ignores the lane selects, or that writes status instead of clearing it, would leave the wrong pattern.

The latency check counts the edges to `irq`. A design with a synchronizer stage missing or added would assert one cycle early or late.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned IDX_W = 4;
  localparam logic [IDX_W-1:0] IDX_ENABLE = 4'd8;
  localparam logic [IDX_W-1:0] IDX_STATUS = 4'd9;
  localparam logic [IDX_W-1:0] IDX_BOTH   = 4'd10;
  localparam logic [IDX_W-1:0] IDX_SELECT = 4'd11;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] rise,
  output logic [NPINS-1:0] fall
);
  logic [NPINS-1:0] stage1_q, stage2_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
      prev_q   <= '0;
    end else begin
      stage1_q <= pin_in;
      stage2_q <= stage1_q;
      prev_q   <= stage2_q;
    end
  end

  assign rise = stage2_q & ~prev_q;
  assign fall = ~stage2_q & prev_q;

  // A pin value reaches the second stage exactly two edges after it was sampled
  AST_SYNC_DEPTH: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (stage2_q == $past(pin_in, 2))); // R2
endmodule

// File: rtl/edge_select.sv
module edge_select #(
  parameter int unsigned NPINS = 32
) (
  input  logic [NPINS-1:0] both_edge,
  input  logic [NPINS-1:0] pick_rise,
  input  logic [NPINS-1:0] rise,
  input  logic [NPINS-1:0] fall,
  output logic [NPINS-1:0] trig
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    always_comb begin
      if (both_edge[p])      trig[p] = rise[p] | fall[p];
      else if (pick_rise[p]) trig[p] = rise[p];
      else                   trig[p] = fall[p];
    end
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  localparam int unsigned LANES = NPINS / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_stb,
  input  logic             reg_we,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [LANES-1:0] reg_be,
  input  logic [NPINS-1:0] reg_wdata,
  input  logic [NPINS-1:0] trig,
  output logic [NPINS-1:0] en_q,
  output logic [NPINS-1:0] both_q,
  output logic [NPINS-1:0] sel_q,
  output logic [NPINS-1:0] status_q,
  output logic [NPINS-1:0] reg_rdata
);
  logic [NPINS-1:0] lane_mask;
  logic wr, wr_en, wr_both, wr_sel, wr_status;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_mask[8*l +: 8] = {8{reg_be[l]}};
  end

  assign wr        = reg_stb && reg_we;
  assign wr_en     = wr && (reg_idx == IDX_ENABLE);
  assign wr_both   = wr && (reg_idx == IDX_BOTH);
  assign wr_sel    = wr && (reg_idx == IDX_SELECT);
  assign wr_status = wr && (reg_idx == IDX_STATUS);

  logic [NPINS-1:0] clr_bits, merged;
  assign clr_bits = wr_status ? (reg_wdata & lane_mask) : '0;
  assign merged   = reg_wdata & lane_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= '0;
      both_q   <= '0;
      sel_q    <= '0;
      status_q <= '0;
    end else begin
      if (wr_en)   en_q   <= (en_q   & ~lane_mask) | merged;
      if (wr_both) both_q <= (both_q & ~lane_mask) | merged;
      if (wr_sel)  sel_q  <= (sel_q  & ~lane_mask) | merged;
      status_q <= (status_q & ~clr_bits) | trig;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_stb && !reg_we) begin
      unique case (reg_idx)
        IDX_ENABLE: reg_rdata <= en_q;
        IDX_STATUS: reg_rdata <= status_q;
        IDX_BOTH:   reg_rdata <= both_q;
        IDX_SELECT: reg_rdata <= sel_q;
        default:    reg_rdata <= '0;
      endcase
    end
  end

  AST_TRIG_LATCHES: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((status_q & $past(trig)) == $past(trig))); // R8
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_status)) |-> ((status_q & $past(status_q)) == $past(status_q))); // R6
  AST_STATUS_NO_SET: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((status_q & ~$past(status_q) & ~$past(trig)) == '0)); // R11
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en)) |-> (en_q == $past(en_q))); // R10
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  localparam int unsigned LANES = NPINS / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_stb,
  input  logic             reg_we,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [LANES-1:0] reg_be,
  input  logic [NPINS-1:0] reg_wdata,
  output logic [NPINS-1:0] reg_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic             irq
);
  logic [NPINS-1:0] rise, fall, trig, en_q, both_q, sel_q, status_q;

  pin_sync #(.NPINS(NPINS)) u_sync (
    .clk(clk), .rst(rst), .pin_in(pin_in), .rise(rise), .fall(fall)
  );

  edge_select #(.NPINS(NPINS)) u_edge (
    .both_edge(both_q), .pick_rise(sel_q), .rise(rise), .fall(fall), .trig(trig)
  );

  irq_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst(rst), .reg_stb(reg_stb), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .trig(trig), .en_q(en_q),
    .both_q(both_q), .sel_q(sel_q), .status_q(status_q), .reg_rdata(reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(status_q & en_q);
  end

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && irq) |-> ($past(en_q) != '0)); // R9
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && irq) |-> ($past(status_q) != '0)); // R9
endmodule

// File: tb/test_gpio_edge_irq.sv
module test_gpio_edge_irq;
  localparam int NP = 32;
  logic clk = 1'b0, rst = 1'b1, reg_stb = 1'b0, reg_we = 1'b0, irq;
  logic [3:0] reg_idx = '0, reg_be = '0;
  logic [NP-1:0] reg_wdata = '0, reg_rdata, pins = '0;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  gpio_edge_irq #(.NPINS(NP)) i_gpio_edge_irq (
    .clk(clk), .rst(rst), .reg_stb(reg_stb), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pins), .irq(irq)
  );

  task automatic chk(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [3:0] be, input logic [NP-1:0] d);
    reg_stb = 1; reg_we = 1; reg_idx = idx; reg_be = be; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_stb = 0; reg_we = 0; reg_be = '0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [NP-1:0] v);
    reg_stb = 1; reg_we = 0; reg_idx = idx;
    @(posedge clk); @(negedge clk);
    v = reg_rdata; reg_stb = 0;
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [NP-1:0] v;
    logic exp_t;
    @(negedge clk); cyc(2); rst = 0; cyc(1);
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, '0);
    for (int r = 8; r < 12; r++) begin rd(4'(r), v); chk("R1 reg", v, '0); end

    // R10 byte-lane config write, ignored index, unknown read
    wr(4'd8, 4'b0011, '1); rd(4'd8, v); chk("R10 lanes", v, 32'h0000_FFFF);
    wr(4'd3, 4'hF, '1);    rd(4'd8, v); chk("R10 other idx", v, 32'h0000_FFFF);
    rd(4'd3, v); chk("R10 unknown read", v, '0);

    // R3 R4 R5 sweep over modes, pins and directions; enable even pins (R9)
    wr(4'd8, 4'hF, 32'h5555_5555);
    for (int m = 0; m < 4; m++) begin
      wr(4'd10, 4'hF, m[1] ? '1 : '0);
      wr(4'd11, 4'hF, m[0] ? '1 : '0);
      for (int i = 0; i < NP; i++) begin
        for (int d = 0; d < 2; d++) begin
          pins[i] = (d == 0);
          cyc(4);
          exp_t = m[1] ? 1'b1 : (m[0] ? (d == 0) : (d == 1));
          chk("R9 irq sweep", {31'b0, irq}, {31'b0, exp_t & (i % 2 == 0)});
          rd(4'd9, v);
          chk(m[1] ? "R5 both" : (m[0] ? "R3 rise" : "R4 fall"), v, exp_t ? (32'h1 << i) : '0);
          wr(4'd9, 4'hF, '1); cyc(2);
          rd(4'd9, v); chk("R7 cleared", v, '0);
          chk("R9 irq low", {31'b0, irq}, '0);
        end
      end
    end

    // R2 latency, both edges, all enabled
    wr(4'd8, 4'hF, '1); wr(4'd10, 4'hF, '1);
    pins[5] = 1'b1;
    cyc(3); chk("R2 irq after 3 edges", {31'b0, irq}, '0);
    cyc(1); chk("R2 irq after 4 edges", {31'b0, irq}, 32'h1);
    wr(4'd9, 4'hF, '1); cyc(2);

    // R7 per-lane clear and R11 no set
    pins ^= 32'h0101_0101; cyc(4);
    rd(4'd9, v); chk("R7 four lanes", v, 32'h0101_0101);
    wr(4'd9, 4'b0101, '1); rd(4'd9, v); chk("R7 lane select", v, 32'h0100_0100);
    wr(4'd9, 4'hF, '0);    rd(4'd9, v); chk("R7 zeros ignored", v, 32'h0100_0100);
    wr(4'd9, 4'hF, '1);    rd(4'd9, v); chk("R11 clear all", v, '0);
    wr(4'd9, 4'hF, '1);    rd(4'd9, v); chk("R11 ones never set", v, '0);

    // R8 trigger on same edge as clear
    pins[3] = ~pins[3];
    cyc(2);
    wr(4'd9, 4'hF, 32'h8);
    rd(4'd9, v); chk("R8 set wins", v, 32'h8);
    wr(4'd9, 4'hF, '1); cyc(1);

    // R6 latch without enable, then enable raises irq
    wr(4'd8, 4'hF, '0);
    pins[7] = ~pins[7]; cyc(10);
    chk("R6 irq masked", {31'b0, irq}, '0);
    rd(4'd9, v); chk("R6 sticky", v, 32'h80);
    wr(4'd8, 4'h1, 32'h80); cyc(1);
    chk("R9 enable raises irq", {31'b0, irq}, 32'h1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule